// File: doc/BRIEF.md
# Overlapped Translation and Cache Lookup Unit

This unit answers a memory access with a single lookup that translates the address and reads the cache in parallel. The upper part of a 32-bit virtual address, the virtual page number, is searched in a small fully associative translation buffer. In the same cycle, the lower part, which translation leaves unchanged, selects a line of a direct-mapped data cache. The physical page number from the translation buffer is then compared with the tag stored in that line. The cache is virtually indexed and physically tagged. The scheme is sound only because every cache index bit and every byte-select bit lies inside the 12-bit page offset.

A request yields a registered response one clock later. The response carries the read word, separate translation-hit and cache-hit flags, and a protection-fault flag. When the translation hits but the line does not match, it raises a memory request with the physical address. When the translation misses, it raises a walk request. Page-table walking and line refill are outside the unit. A test environment or a neighbouring block loads translations and cache lines through two fill ports.

Top module: `vipt_lookup`

## Requirements
- R1: While reset is held, and after it until the first request, every response output is zero. After reset, no translation entry and no cache line is valid.
- R2: Bits [31:12] of the virtual address form the page number searched in the buffer. Bits [11:2] select one of 1024 cache lines. Bits [1:0] do not change the returned word, which is always the whole 32-bit line.
- R3: A response appears on the clock edge after the request, with rsp_valid high. A translation hit is reported when a valid entry's page number equals the request's page number, whatever the entry's position among the 8 entries.
- R4: rsp_cache_hit is high, and rsp_data carries the line, only when the translation hits, the access is permitted, the line is valid, and its stored tag equals the translated page number. In every other case rsp_data is zero.
- R5: A permitted access whose translation hits but whose cache lookup misses raises rsp_mem_req with rsp_mem_pa equal to {physical page number, va[11:0]}. Otherwise rsp_mem_pa is zero.
- R6: A request with no matching translation raises rsp_walk_req, and reports no cache hit, no memory request and zero data.
- R7: Entry rights bit 0 permits reads and bit 1 permits writes. An access its entry does not permit sets rsp_fault, returns zero data, raises no memory request and writes nothing.
- R8: Every translation hit sets the entry's reference bit, including a faulting one. A permitted write sets its dirty bit. rsp_ref and rsp_dirty report the entry's bits as they were before the access, and read zero on a translation miss.
- R9: A permitted write that hits in the cache replaces the stored word with req_wdata.
- R10: Translation fills go to the entries in round-robin order starting at entry 0. A fill clears the entry's reference and dirty bits. The ninth fill therefore evicts the first translation loaded.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill. When a cache fill and a write hit target the same line in one cycle, the fill's data is kept. When a translation fill overwrites the entry a lookup hits, the fill's cleared status bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Write word |
| tlb_fill_en | input | 1 | Load a translation into the round-robin slot |
| tlb_fill_vpn | input | 20 | Virtual page number of the new translation |
| tlb_fill_ppn | input | 20 | Physical page number of the new translation |
| tlb_fill_rights | input | 2 | Rights: bit 0 read, bit 1 write |
| cache_fill_en | input | 1 | Load a cache line |
| cache_fill_line | input | 30 | Physical line address, PA[31:2] |
| cache_fill_data | input | 32 | Line contents |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_tlb_hit | output | 1 | Translation found |
| rsp_cache_hit | output | 1 | Line valid and tag matched |
| rsp_fault | output | 1 | Access not permitted by rights |
| rsp_data | output | 32 | Read word, zero unless cache hit |
| rsp_mem_req | output | 1 | Memory access needed at rsp_mem_pa |
| rsp_mem_pa | output | 32 | Physical address for the memory request |
| rsp_walk_req | output | 1 | Translation missing, walk needed |
| rsp_ref | output | 1 | Entry reference bit before this access |
| rsp_dirty | output | 1 | Entry dirty bit before this access |

## Verification
The lookup and both fill ports can act in the same cycle. So can a write hit and a cache fill that target the same line. Directed cases place a read beside a fill of its own line, a write hit beside a fill of that line, and the ninth translation fill beside a lookup of the entry it evicts. The random phase then drives requests and both fills together from small address pools, so such collisions recur often. A bench model applies each cycle's lookup to the pre-edge state and then lets the fills overwrite. It judges the response on the following cycle, and later reads show which write survived.

// File: rtl/vipt_pkg.sv
// Shared constants for the overlapped lookup unit.
// Assumes: rights field is two bits, read permission in bit 0, write in bit 1.
package vipt_pkg;
    localparam int VA_BITS       = 32;
    localparam int PA_BITS       = 32;
    localparam int PAGE_BITS     = 12;
    localparam int LINE_OFS_BITS = 2;
    localparam int TLB_DEPTH     = 8;
    localparam int RIGHTS_BITS   = 2;
    localparam int RIGHT_RD      = 0;
    localparam int RIGHT_WR      = 1;

    // Whether the rights field allows the requested kind of access.
    function automatic logic access_ok(input logic [RIGHTS_BITS-1:0] rights,
                                       input logic is_write);
        return is_write ? rights[RIGHT_WR] : rights[RIGHT_RD];
    endfunction
endpackage

// File: rtl/vipt_tlb.sv
// Fully associative translation buffer with round-robin fill.
// Lookup is combinational from the stored entries. Status update and fill take
// effect at the clock edge, and a fill of the same slot overrides the update.
// Assumes the filler never loads a page number that is already present.
module vipt_tlb #(
    parameter int ENTRIES  = vipt_pkg::TLB_DEPTH,
    parameter int VPN_W    = 20,
    parameter int PPN_W    = 20,
    parameter int RIGHTS_W = vipt_pkg::RIGHTS_BITS,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VPN_W-1:0]    lk_vpn,
    output logic                lk_hit,
    output logic [IDX_W-1:0]    lk_idx,
    output logic [PPN_W-1:0]    lk_ppn,
    output logic [RIGHTS_W-1:0] lk_rights,
    output logic                lk_ref,
    output logic                lk_dirty,
    input  logic                upd_en,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic                upd_dirty,
    input  logic                fill_en,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [RIGHTS_W-1:0] fill_rights
);
    logic [VPN_W-1:0]    vpn_q    [ENTRIES];
    logic [PPN_W-1:0]    ppn_q    [ENTRIES];
    logic [RIGHTS_W-1:0] rights_q [ENTRIES];
    logic [ENTRIES-1:0]  valid_q, ref_q, dirty_q, match;
    logic [IDX_W-1:0]    ptr_q;

    // Round-robin victim pointer, advanced on every fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (fill_en)
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        // Page-number comparator of one entry.
        assign match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);

        // Valid and status bits: fill clears status, a hit sets reference/dirty.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                ref_q[i]   <= 1'b0;
                dirty_q[i] <= 1'b0;
            end else if (fill_en && ptr_q == IDX_W'(i)) begin
                valid_q[i] <= 1'b1;
                ref_q[i]   <= 1'b0;
                dirty_q[i] <= 1'b0;
            end else if (upd_en && upd_idx == IDX_W'(i)) begin
                ref_q[i] <= 1'b1;
                if (upd_dirty)
                    dirty_q[i] <= 1'b1;
            end
        end

        // Translation payload, written only by a fill.
        always_ff @(posedge clk) begin
            if (fill_en && ptr_q == IDX_W'(i)) begin
                vpn_q[i]    <= fill_vpn;
                ppn_q[i]    <= fill_ppn;
                rights_q[i] <= fill_rights;
            end
        end
    end

    // Encode the matching slot, lowest index first.
    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
        end
    end

    // Read out the selected entry, zero on a miss.
    always_comb begin
        lk_ppn    = lk_hit ? ppn_q[lk_idx]    : '0;
        lk_rights = lk_hit ? rights_q[lk_idx] : '0;
        lk_ref    = lk_hit && ref_q[lk_idx];
        lk_dirty  = lk_hit && dirty_q[lk_idx];
    end
endmodule

// File: rtl/vipt_dcache.sv
// Direct-mapped cache array: per-line valid bit, physical tag and one data word.
// Read is combinational by index. Write and fill land at the edge, and a fill
// to the same line as a write keeps the fill's word.
module vipt_dcache #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Line valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (fill_en)
            valid_q[fill_idx] <= 1'b1;
    end

    // Tag and data storage: write hit first, fill last so it wins a collision.
    always_ff @(posedge clk) begin
        if (wr_en && !(fill_en && fill_idx == wr_idx))
            data_q[wr_idx] <= wr_data;
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_data;
        end
    end

    // Indexed read of the selected line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end
endmodule

// File: rtl/vipt_decide.sv
// Combinational hit, permission and miss-routing decision for one access.
// Inputs come from the translation buffer and the cache array in the same cycle.
module vipt_decide #(
    parameter int PPN_W    = 20,
    parameter int DATA_W   = 32,
    parameter int RIGHTS_W = vipt_pkg::RIGHTS_BITS
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                tlb_hit,
    input  logic [RIGHTS_W-1:0] tlb_rights,
    input  logic [PPN_W-1:0]    tlb_ppn,
    input  logic                line_valid,
    input  logic [PPN_W-1:0]    line_tag,
    input  logic [DATA_W-1:0]   line_data,
    output logic                hit_tlb,
    output logic                permit,
    output logic                fault,
    output logic                cache_hit,
    output logic                mem_req,
    output logic                walk_req,
    output logic [DATA_W-1:0]   data_out
);
    // Rights check and physical tag compare, gated by the request.
    always_comb begin
        hit_tlb   = req_valid && tlb_hit;
        permit    = hit_tlb && vipt_pkg::access_ok(tlb_rights, req_write);
        fault     = hit_tlb && !permit;
        cache_hit = permit && line_valid && (line_tag == tlb_ppn);
        mem_req   = permit && !cache_hit;
        walk_req  = req_valid && !tlb_hit;
        data_out  = cache_hit ? line_data : '0;
    end
endmodule

// File: rtl/vipt_lookup.sv
// Top of the overlapped translation and cache lookup unit.
// The page number drives the translation buffer while the page offset indexes
// the cache in the same cycle. The cache index width is derived from the page
// and line sizes, so index bits never leave the untranslated offset.
// Response is registered: one cycle from request to result.
module vipt_lookup #(
    parameter int VA_W        = vipt_pkg::VA_BITS,
    parameter int PA_W        = vipt_pkg::PA_BITS,
    parameter int PAGE_W      = vipt_pkg::PAGE_BITS,
    parameter int LINE_OFS_W  = vipt_pkg::LINE_OFS_BITS,
    parameter int TLB_ENTRIES = vipt_pkg::TLB_DEPTH,
    localparam int VPN_W      = VA_W - PAGE_W,
    localparam int PPN_W      = PA_W - PAGE_W,
    localparam int IDX_W      = PAGE_W - LINE_OFS_W,
    localparam int DATA_W     = 8 << LINE_OFS_W,
    localparam int RIGHTS_W   = vipt_pkg::RIGHTS_BITS,
    localparam int TIDX_W     = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_write,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  tlb_fill_en,
    input  logic [VPN_W-1:0]      tlb_fill_vpn,
    input  logic [PPN_W-1:0]      tlb_fill_ppn,
    input  logic [RIGHTS_W-1:0]   tlb_fill_rights,
    input  logic                  cache_fill_en,
    input  logic [PA_W-LINE_OFS_W-1:0] cache_fill_line,
    input  logic [DATA_W-1:0]     cache_fill_data,
    output logic                  rsp_valid,
    output logic                  rsp_tlb_hit,
    output logic                  rsp_cache_hit,
    output logic                  rsp_fault,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  rsp_mem_req,
    output logic [PA_W-1:0]       rsp_mem_pa,
    output logic                  rsp_walk_req,
    output logic                  rsp_ref,
    output logic                  rsp_dirty
);
    logic [VPN_W-1:0]    va_vpn;
    logic [IDX_W-1:0]    va_idx;
    logic                t_hit, t_ref, t_dirty;
    logic [TIDX_W-1:0]   t_idx;
    logic [PPN_W-1:0]    t_ppn;
    logic [RIGHTS_W-1:0] t_rights;
    logic                c_valid;
    logic [PPN_W-1:0]    c_tag;
    logic [DATA_W-1:0]   c_data;
    logic                d_tlb, d_permit, d_fault, d_chit, d_mreq, d_walk;
    logic [DATA_W-1:0]   d_data;

    // Split the virtual address into translated and untranslated parts.
    assign va_vpn = req_va[VA_W-1:PAGE_W];
    assign va_idx = req_va[PAGE_W-1:LINE_OFS_W];

    vipt_tlb #(
        .ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)
    ) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (va_vpn),
        .lk_hit     (t_hit),
        .lk_idx     (t_idx),
        .lk_ppn     (t_ppn),
        .lk_rights  (t_rights),
        .lk_ref     (t_ref),
        .lk_dirty   (t_dirty),
        .upd_en     (d_tlb),
        .upd_idx    (t_idx),
        .upd_dirty  (d_permit && req_write),
        .fill_en    (tlb_fill_en),
        .fill_vpn   (tlb_fill_vpn),
        .fill_ppn   (tlb_fill_ppn),
        .fill_rights(tlb_fill_rights)
    );

    vipt_dcache #(
        .IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (va_idx),
        .rd_valid (c_valid),
        .rd_tag   (c_tag),
        .rd_data  (c_data),
        .wr_en    (d_chit && req_write),
        .wr_idx   (va_idx),
        .wr_data  (req_wdata),
        .fill_en  (cache_fill_en),
        .fill_idx (cache_fill_line[IDX_W-1:0]),
        .fill_tag (cache_fill_line[PA_W-LINE_OFS_W-1:IDX_W]),
        .fill_data(cache_fill_data)
    );

    vipt_decide #(
        .PPN_W(PPN_W), .DATA_W(DATA_W), .RIGHTS_W(RIGHTS_W)
    ) u_decide (
        .req_valid (req_valid),
        .req_write (req_write),
        .tlb_hit   (t_hit),
        .tlb_rights(t_rights),
        .tlb_ppn   (t_ppn),
        .line_valid(c_valid),
        .line_tag  (c_tag),
        .line_data (c_data),
        .hit_tlb   (d_tlb),
        .permit    (d_permit),
        .fault     (d_fault),
        .cache_hit (d_chit),
        .mem_req   (d_mreq),
        .walk_req  (d_walk),
        .data_out  (d_data)
    );

    // Response register: captures this cycle's decision for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_tlb_hit   <= 1'b0;
            rsp_cache_hit <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_data      <= '0;
            rsp_mem_req   <= 1'b0;
            rsp_mem_pa    <= '0;
            rsp_walk_req  <= 1'b0;
            rsp_ref       <= 1'b0;
            rsp_dirty     <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_tlb_hit   <= d_tlb;
            rsp_cache_hit <= d_chit;
            rsp_fault     <= d_fault;
            rsp_data      <= d_data;
            rsp_mem_req   <= d_mreq;
            rsp_mem_pa    <= d_mreq ? {t_ppn, req_va[PAGE_W-1:0]} : '0;
            rsp_walk_req  <= d_walk;
            rsp_ref       <= d_tlb && t_ref;
            rsp_dirty     <= d_tlb && t_dirty;
        end
    end
endmodule

// File: rtl/vipt_lookup_chk.sv
// Port-level property checker for vipt_lookup, attached by bind below.
module vipt_lookup_chk #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_va,
    input logic              rsp_valid,
    input logic              rsp_tlb_hit,
    input logic              rsp_cache_hit,
    input logic              rsp_fault,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_mem_req,
    input logic [PA_W-1:0]   rsp_mem_pa,
    input logic              rsp_walk_req,
    input logic              rsp_ref,
    input logic              rsp_dirty
);
    // R3: a request is answered on the next edge, and only a request is.
    a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r3_no_rsp_unasked: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1: with no response, every flag and word stays zero.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_tlb_hit || rsp_cache_hit || rsp_fault || rsp_mem_req
                         || rsp_walk_req || rsp_ref || rsp_dirty)
                       && rsp_data == '0 && rsp_mem_pa == '0);

    // R4: a cache hit needs a permitted translation hit; a miss returns zero.
    a_r4_hit_needs_xlate: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cache_hit |-> rsp_tlb_hit && !rsp_fault && !rsp_mem_req);
    a_r4_miss_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_cache_hit |-> rsp_data == '0);

    // R5: the memory request keeps the untranslated offset of the request.
    a_r5_pa_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mem_req |-> rsp_mem_pa[PAGE_W-1:0] == $past(req_va[PAGE_W-1:0]));

    // R6: a walk is requested exactly when a valid response missed the buffer.
    a_r6_walk_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_walk_req == !rsp_tlb_hit));
    a_r6_walk_nothing_else: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_walk_req |-> !rsp_mem_req && !rsp_fault && !rsp_ref && !rsp_dirty);

    // R7: a faulting access returns nothing and asks memory for nothing.
    a_r7_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_tlb_hit && !rsp_cache_hit && !rsp_mem_req && rsp_data == '0);
endmodule

bind vipt_lookup vipt_lookup_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .rsp_valid    (rsp_valid),
    .rsp_tlb_hit  (rsp_tlb_hit),
    .rsp_cache_hit(rsp_cache_hit),
    .rsp_fault    (rsp_fault),
    .rsp_data     (rsp_data),
    .rsp_mem_req  (rsp_mem_req),
    .rsp_mem_pa   (rsp_mem_pa),
    .rsp_walk_req (rsp_walk_req),
    .rsp_ref      (rsp_ref),
    .rsp_dirty    (rsp_dirty)
);

// File: tb/tb_vipt_lookup.sv
// Bench for vipt_lookup: directed collisions plus seeded random traffic,
// compared each cycle with a behavioural model of translations and lines.
module tb_vipt_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_va = '0, req_wdata = '0;
    logic        tlb_fill_en = 1'b0;
    logic [19:0] tlb_fill_vpn = '0, tlb_fill_ppn = '0;
    logic [1:0]  tlb_fill_rights = '0;
    logic        cache_fill_en = 1'b0;
    logic [29:0] cache_fill_line = '0;
    logic [31:0] cache_fill_data = '0;
    logic        rsp_valid, rsp_tlb_hit, rsp_cache_hit, rsp_fault;
    logic [31:0] rsp_data, rsp_mem_pa;
    logic        rsp_mem_req, rsp_walk_req, rsp_ref, rsp_dirty;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vipt_lookup dut (.*);

    // Model state.
    bit        m_tv [8];
    bit [19:0] m_vpn [8], m_ppn [8];
    bit [1:0]  m_rt [8];
    bit        m_ref [8], m_dirty [8];
    int        m_ptr = 0;
    bit        c_v [1024];
    bit [19:0] c_tag [1024];
    bit [31:0] c_data [1024];

    function automatic int find_vpn(input bit [19:0] vpn);
        for (int i = 0; i < 8; i++)
            if (m_tv[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic bit [71:0] pack_act();
        return {rsp_valid, rsp_tlb_hit, rsp_cache_hit, rsp_fault, rsp_mem_req,
                rsp_walk_req, rsp_ref, rsp_dirty, rsp_data, rsp_mem_pa};
    endfunction

    task automatic check(input string tag, input bit [71:0] exp);
        bit [71:0] act = pack_act();
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, model it, check at the next falling edge.
    task automatic step(input string tag, input bit rv, input bit [31:0] va,
                        input bit wr, input bit [31:0] wd,
                        input bit tf, input bit [19:0] tvpn, input bit [19:0] tppn,
                        input bit [1:0] trt,
                        input bit cf, input bit [29:0] cline, input bit [31:0] cdat);
        int ti;
        bit th, ok, ch, mr;
        bit [9:0] ci;
        bit [71:0] exp;
        req_valid = rv; req_va = va; req_write = wr; req_wdata = wd;
        tlb_fill_en = tf; tlb_fill_vpn = tvpn; tlb_fill_ppn = tppn; tlb_fill_rights = trt;
        cache_fill_en = cf; cache_fill_line = cline; cache_fill_data = cdat;
        ti = find_vpn(va[31:12]);
        th = rv && ti >= 0;
        ok = th && (wr ? m_rt[ti][1] : m_rt[ti][0]);
        ci = va[11:2];
        ch = ok && c_v[ci] && c_tag[ci] == m_ppn[ti];
        mr = ok && !ch;
        exp = {rv, th, ch, th && !ok, mr, rv && ti < 0,
               th && m_ref[ti], th && m_dirty[ti],
               ch ? c_data[ci] : 32'h0,
               mr ? {m_ppn[ti], va[11:0]} : 32'h0};
        if (th) begin
            m_ref[ti] = 1'b1;
            if (ok && wr) m_dirty[ti] = 1'b1;
        end
        if (ch && wr) c_data[ci] = wd;
        if (tf) begin
            m_tv[m_ptr] = 1'b1; m_vpn[m_ptr] = tvpn; m_ppn[m_ptr] = tppn;
            m_rt[m_ptr] = trt; m_ref[m_ptr] = 1'b0; m_dirty[m_ptr] = 1'b0;
            m_ptr = (m_ptr + 1) % 8;
        end
        if (cf) begin
            c_v[cline[9:0]] = 1'b1; c_tag[cline[9:0]] = cline[29:10];
            c_data[cline[9:0]] = cdat;
        end
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic rd(input string tag, input bit [31:0] va);
        step(tag, 1, va, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wrt(input string tag, input bit [31:0] va, input bit [31:0] wd);
        step(tag, 1, va, 1, wd, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic tfill(input string tag, input bit [19:0] v, input bit [19:0] p,
                         input bit [1:0] r);
        step(tag, 0, 0, 0, 0, 1, v, p, r, 0, 0, 0);
    endtask
    task automatic cfill(input string tag, input bit [29:0] l, input bit [31:0] d);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, l, d);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1bad5eed));
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset.
        check("R1 in reset", 72'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 72'h0);
        // R1 R6: empty buffer -> walk request.
        rd("R6 empty walk", 32'h1234_5678);

        // R3 R5: translation hit, line invalid -> memory request with PA.
        tfill("R10 fill0", 20'h12345, 20'hABCDE, 2'b11);
        rd("R5 miss to memory", 32'h1234_5678);
        // R2 R4: filled line hits; byte-select bits do not matter; ref now 1 (R8).
        cfill("R4 line fill", {20'hABCDE, 10'h19E}, 32'hCAFE_F00D);
        rd("R2 byte bits ignored", 32'h1234_567B);
        // R4: same index, other page: tag mismatch -> memory request.
        tfill("R10 fill1", 20'h00042, 20'h11111, 2'b01);
        rd("R4 tag mismatch", 32'h0004_2678);
        // R7: write to read-only page faults; dirty stays clear (R8).
        wrt("R7 write fault", 32'h0004_2678, 32'hDEAD_0000);
        rd("R8 dirty unchanged", 32'h0004_2678);
        // R9 R8: permitted write hit updates data and sets dirty.
        wrt("R9 write hit", 32'h1234_5678, 32'h0BAD_BEEF);
        rd("R9 readback dirty", 32'h1234_5679);
        // R11: read beside a fill of the same line sees the old word.
        step("R11 read vs fill", 1, 32'h1234_5678, 0, 0, 0, 0, 0, 0,
             1, {20'hABCDE, 10'h19E}, 32'h5555_AAAA);
        rd("R11 new word", 32'h1234_5678);
        // R11: write hit and fill of the same line in one cycle: fill kept.
        step("R11 write vs fill", 1, 32'h1234_5678, 1, 32'h7777_7777, 0, 0, 0, 0,
             1, {20'hABCDE, 10'h19E}, 32'h9999_0000);
        rd("R11 fill won", 32'h1234_5678);
        // R10: fill six more, then the ninth evicts the first; lookup beside it hits.
        for (int k = 0; k < 6; k++)
            tfill("R10 fill more", 20'h70000 + 20'(k), 20'h20000 + 20'(k), 2'b10);
        rd("R3 last slot hit", 32'h7000_5000 + 32'h0); // R7: write-only page read faults
        step("R11 lookup vs evict", 1, 32'h1234_5678, 0, 0, 1, 20'h7ABCD, 20'h00001, 2'b11,
             0, 0, 0);
        rd("R10 evicted walk", 32'h1234_5678);
        rd("R10 new entry", 32'h7ABC_D000);

        // Random phase mixing requests and both fills.
        for (int n = 0; n < 4000; n++) begin
            bit rv, wr, tf, cf;
            bit [19:0] tv, tp;
            bit [31:0] va;
            rv = ($urandom % 4) != 0;
            wr = $urandom % 2;
            va = {20'h80000 + 20'($urandom % 12), 7'h0, 3'($urandom % 8), 2'($urandom)};
            tf = ($urandom % 6) == 0;
            tv = 20'h80000 + 20'($urandom % 12);
            tp = 20'h30000 + 20'($urandom % 6);
            if (find_vpn(tv) >= 0) tf = 0;
            cf = ($urandom % 3) == 0;
            step("R3 R4 R5 R8 R9 R11 random", rv, va, wr, $urandom, tf, tv, tp,
                 2'($urandom), cf,
                 {20'h30000 + 20'($urandom % 6), 7'h0, 3'($urandom % 8)}, $urandom);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule